// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is one communication cell shared by several requesters, such as hardware threads. It holds a small FIFO of data words and a tag made of an Empty flag, a Full flag, a spare T flag and a fill count. Each access picks one of four access views with a 2-bit code, and each view gives the same storage a different meaning:

- **Raw view**: peek at the oldest word, or poke the newest one.
- **Tag view**: read or write the tag word.
- **Blocking view**: push or pop, but refuse with a stall when the cell is empty or full.
- **Non-blocking view**: push or pop, and never refuse.

Every access carries a requester ID. When a blocking access is refused, the cell returns a one-cycle stall response and sets the requester's bit in a blocked mask. The next push or pop through either queue view that completes sends the whole mask out on the wake bus for one cycle and then clears the mask. The requesters can then retry.

All outputs are registered. Read data, stall and wake for the access sampled at one clock edge are valid after that edge, until the next edge. The depth must be a power of two.

Read and write strobes should not be raised together. If both are high, the read is performed and the write is dropped.

The parameter `FIFO_MODE` picks a plain tagged word instead of a queue. In that variant the queue views do nothing.

Top module: `tfc_cell`

## Requirements
- R1: After reset the tag word reads `{log2(DEPTH)` at bits 31:28, count 0 at bits 18 and up, FIFO flag 1 at bit 17, T 0 at bit 16, F 0 at bit 1, E 1 at bit 0`}`. With default parameters this is 0x30020001. `stall_o` and `wake_o` are 0.
- R2: A write through the tag view (code 1) loads only T (bit 16), F (bit 1) and E (bit 0) from the write data. Writing E=1 also clears the fill count. All other written bits are ignored.
- R3: A non-blocking push (view code 3) stores the word and raises the count. Pops return words in push order, including when the storage pointer wraps. An access through the raw, tag or non-blocking view never stalls.
- R4: The count never exceeds DEPTH. F is set when a push brings the count to DEPTH. A non-blocking push into a full cell stores nothing.
- R5: A pop takes the oldest word and sets E when the count reaches zero. A non-blocking pop of an empty cell returns 0.
- R6: A blocking pop (view code 2) while E is set gives `stall_o` for one cycle, records the requester ID, and does not change data or count. The only tag change is that F is cleared.
- R7: A blocking push while F is set gives `stall_o` for one cycle and stores nothing. The only tag change is that E is cleared.
- R8: A push or pop through view 2 or 3 that completes while the blocked mask is non-empty drives that mask on `wake_o` for exactly one cycle, then empties the mask. Stall and wake never occur together.
- R9: A raw read (view code 0) returns the oldest word without removing it. A raw write replaces the newest word, and only when the count is non-zero.
- R10: With `FIFO_MODE`=0, pushes and pops through views 2 and 3 leave the tag unchanged, return 0 and never stall. The tag reads all zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| view_i | input | 2 | Access view: 0 raw, 1 tag, 2 blocking queue, 3 non-blocking queue |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| req_id_i | input | ID_W | ID of the requester making the access |
| rdata_o | output | DATA_W | Read data for the access sampled at the previous edge |
| stall_o | output | 1 | Previous blocking access was refused |
| wake_o | output | 2**ID_W | One-cycle pulse of the blocked-requester mask |

## Verification
The hardest state to reach is a wake pulse carrying several requester bits. To get there, two blocking pops with different IDs must be refused on an empty cell, and then a different access must complete. The stimulus does exactly that, then checks that the pulse holds the union of both IDs and is gone one cycle later.

A second hard case is a blocking push against a full cell. The stimulus reaches it only after the output pointer has been moved by earlier pops, so the drain of all eight entries also checks that the pointer wraps correctly.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic [1:0] {
    VIEW_RAW = 2'd0,
    VIEW_TAG = 2'd1,
    VIEW_BLK = 2'd2,
    VIEW_NB  = 2'd3
  } view_e;

  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_MEM  = 2'd1,
    RSEL_TAG  = 2'd2
  } rsel_e;

  localparam int TAG_W        = 32;
  localparam int TAG_DEPTH_LSB = 28;
  localparam int TAG_CNT_LSB  = 18;
  localparam int TAG_FIFO_BIT = 17;
  localparam int TAG_T_BIT    = 16;
  localparam int TAG_F_BIT    = 1;
  localparam int TAG_E_BIT    = 0;
endpackage

// File: rtl/tfc_store.sv
module tfc_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tfc_ctrl.sv
module tfc_ctrl
  import tfc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ID_W      = 6,
  parameter bit FIFO_MODE = 1'b1,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int MASK_W = 1 << ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  view_e             view,
  input  logic              rd,
  input  logic              wr,
  input  logic              new_t,
  input  logic              new_f,
  input  logic              new_e,
  input  logic [ID_W-1:0]   id,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_waddr,
  output logic [PTR_W-1:0]  out_ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              t_flag,
  output logic              f_flag,
  output logic              e_flag,
  output rsel_e             rsel_q,
  output logic              stall_q,
  output logic [MASK_W-1:0] wake_q
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [MASK_W-1:0] mask_q, mask_n, wake_n;
  logic [PTR_W-1:0]  out_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              t_n, f_n, e_n, stall_n;
  rsel_e             rsel_n;
  logic              acc_rd, acc_wr, blk;
  logic [MASK_W-1:0] id_bit;

  assign acc_rd = rd;
  assign acc_wr = wr & ~rd;
  assign blk    = (view == VIEW_BLK);
  assign id_bit = MASK_W'(1) << id;

  always_comb begin
    out_n     = out_ptr;
    cnt_n     = cnt;
    t_n       = t_flag;
    f_n       = f_flag;
    e_n       = e_flag;
    mask_n    = mask_q;
    wake_n    = '0;
    stall_n   = 1'b0;
    rsel_n    = RSEL_ZERO;
    mem_we    = 1'b0;
    mem_waddr = out_ptr + cnt[PTR_W-1:0];
    case (view)
      VIEW_RAW: begin
        if (acc_rd) rsel_n = RSEL_MEM;
        if (acc_wr && FIFO_MODE && cnt != '0) begin
          mem_we    = 1'b1;
          mem_waddr = out_ptr + cnt[PTR_W-1:0] - PTR_W'(1);
        end
      end
      VIEW_TAG: begin
        if (acc_rd) rsel_n = RSEL_TAG;
        if (acc_wr) begin
          t_n = new_t;
          f_n = new_f;
          e_n = new_e;
          if (new_e) cnt_n = '0;
        end
      end
      default: begin
        if (FIFO_MODE && acc_rd) begin
          f_n = 1'b0;
          if (blk && e_flag) begin
            mask_n  = mask_q | id_bit;
            stall_n = 1'b1;
          end else begin
            if (mask_q != '0) begin
              wake_n = mask_q;
              mask_n = '0;
            end
            if (cnt != '0) begin
              rsel_n = RSEL_MEM;
              out_n  = out_ptr + PTR_W'(1);
              cnt_n  = cnt - CNT_W'(1);
            end
            e_n = e_flag | (cnt_n == '0);
          end
        end else if (FIFO_MODE && acc_wr) begin
          e_n = 1'b0;
          if (blk && f_flag) begin
            mask_n  = mask_q | id_bit;
            stall_n = 1'b1;
          end else begin
            if (mask_q != '0) begin
              wake_n = mask_q;
              mask_n = '0;
            end
            if (cnt < FULL_CNT) begin
              mem_we = 1'b1;
              cnt_n  = cnt + CNT_W'(1);
            end
            f_n = f_flag | (cnt_n == FULL_CNT);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_ptr <= '0;
      cnt     <= '0;
      t_flag  <= 1'b0;
      f_flag  <= 1'b0;
      e_flag  <= FIFO_MODE;
      mask_q  <= '0;
      wake_q  <= '0;
      stall_q <= 1'b0;
      rsel_q  <= RSEL_ZERO;
    end else begin
      out_ptr <= out_n;
      cnt     <= cnt_n;
      t_flag  <= t_n;
      f_flag  <= f_n;
      e_flag  <= e_n;
      mask_q  <= mask_n;
      wake_q  <= wake_n;
      stall_q <= stall_n;
      rsel_q  <= rsel_n;
    end
  end
endmodule

// File: rtl/tfc_cell.sv
module tfc_cell
  import tfc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 6,
  parameter bit FIFO_MODE = 1'b1,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int MASK_W = 1 << ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        view_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stall_o,
  output logic [MASK_W-1:0] wake_o
);
  localparam logic [3:0] DEPTH_CODE = FIFO_MODE ? 4'(PTR_W) : 4'd0;

  logic              mem_we;
  logic [PTR_W-1:0]  mem_waddr, out_ptr;
  logic [CNT_W-1:0]  cnt_w;
  logic              t_flag, f_flag, e_flag;
  rsel_e             rsel_q;
  logic [DATA_W-1:0] mem_q;
  logic [TAG_W-1:0]  tag_word, tag_q;

  tfc_ctrl #(.DEPTH(DEPTH), .ID_W(ID_W), .FIFO_MODE(FIFO_MODE)) ctrl_i (
    .clk(clk), .rst(rst), .view(view_e'(view_i)), .rd(rd_i), .wr(wr_i),
    .new_t(wdata_i[TAG_T_BIT]), .new_f(wdata_i[TAG_F_BIT]),
    .new_e(wdata_i[TAG_E_BIT]), .id(req_id_i),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .out_ptr(out_ptr), .cnt(cnt_w),
    .t_flag(t_flag), .f_flag(f_flag), .e_flag(e_flag),
    .rsel_q(rsel_q), .stall_q(stall_o), .wake_q(wake_o)
  );

  tfc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wdata_i),
    .raddr(out_ptr), .rdata(mem_q)
  );

  always_comb begin
    tag_word = '0;
    tag_word[TAG_DEPTH_LSB +: 4]     = DEPTH_CODE;
    tag_word[TAG_CNT_LSB +: CNT_W]   = cnt_w;
    tag_word[TAG_FIFO_BIT]           = FIFO_MODE;
    tag_word[TAG_T_BIT]              = t_flag;
    tag_word[TAG_F_BIT]              = f_flag;
    tag_word[TAG_E_BIT]              = e_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) tag_q <= '0;
    else     tag_q <= tag_word;
  end

  always_comb begin
    case (rsel_q)
      RSEL_MEM: rdata_o = mem_q;
      RSEL_TAG: rdata_o = DATA_W'(tag_q);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tfc_cell_chk.sv
module tfc_cell_chk
  import tfc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 6,
  localparam int CNT_W  = $clog2(DEPTH) + 1,
  localparam int MASK_W = 1 << ID_W
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        view_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              stall_o,
  input logic [MASK_W-1:0] wake_o,
  input logic [CNT_W-1:0]  cnt
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == '0 && !stall_o && wake_o == '0)); // R1
  AST_NB_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || wr_i) && view_i != VIEW_BLK) |=> !stall_o); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH)); // R4
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> $past((rd_i || wr_i) && view_i == VIEW_BLK)); // R6
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wake_o != '0) |=> (wake_o == '0)); // R8
  AST_STALL_XOR_WAKE: assert property (@(posedge clk) disable iff (rst)
    !(stall_o && wake_o != '0)); // R8
endmodule

bind tfc_cell tfc_cell_chk #(.DEPTH(DEPTH), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst(rst), .view_i(view_i), .rd_i(rd_i), .wr_i(wr_i),
  .stall_o(stall_o), .wake_o(wake_o), .cnt(cnt_w)
);

// File: tb/tfc_cell_tb.sv
module tfc_cell_tb_top;
  import tfc_pkg::*;

  typedef struct packed {
    logic [1:0]  v;
    logic        rd;
    logic        wr;
    logic [31:0] d;
    logic [5:0]  id;
    logic [31:0] er;
    logic        es;
    logic [63:0] ew;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{VIEW_TAG, 1'b1, 1'b0, 32'h0,  6'd0, 32'h30020001, 1'b0, 64'h0,   4'd1},  // R1
    '{VIEW_NB,  1'b0, 1'b1, 32'hA1, 6'd0, 32'h0,        1'b0, 64'h0,   4'd3},  // R3
    '{VIEW_NB,  1'b0, 1'b1, 32'hA2, 6'd0, 32'h0,        1'b0, 64'h0,   4'd3},
    '{VIEW_TAG, 1'b1, 1'b0, 32'h0,  6'd0, 32'h300A0000, 1'b0, 64'h0,   4'd3},
    '{VIEW_RAW, 1'b1, 1'b0, 32'h0,  6'd0, 32'hA1,       1'b0, 64'h0,   4'd9},  // R9
    '{VIEW_RAW, 1'b0, 1'b1, 32'hB2, 6'd0, 32'h0,        1'b0, 64'h0,   4'd9},
    '{VIEW_NB,  1'b1, 1'b0, 32'h0,  6'd0, 32'hA1,       1'b0, 64'h0,   4'd3},
    '{VIEW_NB,  1'b1, 1'b0, 32'h0,  6'd0, 32'hB2,       1'b0, 64'h0,   4'd9},
    '{VIEW_TAG, 1'b1, 1'b0, 32'h0,  6'd0, 32'h30020001, 1'b0, 64'h0,   4'd5},  // R5
    '{VIEW_NB,  1'b1, 1'b0, 32'h0,  6'd0, 32'h0,        1'b0, 64'h0,   4'd5},
    '{VIEW_BLK, 1'b1, 1'b0, 32'h0,  6'd5, 32'h0,        1'b1, 64'h0,   4'd6},  // R6
    '{VIEW_BLK, 1'b1, 1'b0, 32'h0,  6'd9, 32'h0,        1'b1, 64'h0,   4'd6},
    '{VIEW_TAG, 1'b1, 1'b0, 32'h0,  6'd0, 32'h30020001, 1'b0, 64'h0,   4'd6},
    '{VIEW_NB,  1'b0, 1'b1, 32'hC3, 6'd0, 32'h0,        1'b0, 64'h220, 4'd8},  // R8
    '{VIEW_TAG, 1'b1, 1'b0, 32'h0,  6'd0, 32'h30060000, 1'b0, 64'h0,   4'd8},
    '{VIEW_BLK, 1'b1, 1'b0, 32'h0,  6'd1, 32'hC3,       1'b0, 64'h0,   4'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  view_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [5:0]  req_id_i = '0;
  logic [31:0] rdata_o, rdata_nf;
  logic        stall_o, stall_nf;
  logic [63:0] wake_o, wake_nf;
  logic [31:0] cap_rd, cap_rd_nf;
  logic        cap_st, cap_st_nf;
  logic [63:0] cap_wk;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  tfc_cell dut_i (
    .clk(clk), .rst(rst), .view_i(view_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .req_id_i(req_id_i),
    .rdata_o(rdata_o), .stall_o(stall_o), .wake_o(wake_o)
  );

  tfc_cell #(.FIFO_MODE(1'b0)) dut_nf_i (
    .clk(clk), .rst(rst), .view_i(view_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .req_id_i(req_id_i),
    .rdata_o(rdata_nf), .stall_o(stall_nf), .wake_o(wake_nf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] v, input logic r, input logic w,
                     input logic [31:0] d, input logic [5:0] id);
    @(negedge clk);
    view_i = v; rd_i = r; wr_i = w; wdata_i = d; req_id_i = id;
    @(posedge clk);
    #1;
    cap_rd = rdata_o; cap_st = stall_o; cap_wk = wake_o;
    cap_rd_nf = rdata_nf; cap_st_nf = stall_nf;
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 stall after reset", {63'd0, stall_o}, 64'd0);
    chk("R1 wake after reset", wake_o, 64'd0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].v, VEC[i].rd, VEC[i].wr, VEC[i].d, VEC[i].id);
      if (VEC[i].rd)
        chk($sformatf("R%0d vec %0d rdata", VEC[i].rq, i), {32'd0, cap_rd}, {32'd0, VEC[i].er});
      chk($sformatf("R%0d vec %0d stall", VEC[i].rq, i), {63'd0, cap_st}, {63'd0, VEC[i].es});
      chk($sformatf("R%0d vec %0d wake", VEC[i].rq, i), cap_wk, VEC[i].ew);
    end

    // R4: fill to depth across the pointer wrap (out pointer is now 3)
    for (int i = 0; i < 8; i++) acc(VIEW_NB, 1'b0, 1'b1, 32'h100 + i, 6'd0);
    acc(VIEW_TAG, 1'b1, 1'b0, 0, 0);
    chk("R4 full tag", {32'd0, cap_rd}, 64'h30220002);
    acc(VIEW_NB, 1'b0, 1'b1, 32'hDEAD, 6'd0);
    chk("R4 push into full no stall", {63'd0, cap_st}, 64'd0);
    // R7: blocking push on full
    acc(VIEW_BLK, 1'b0, 1'b1, 32'hBEEF, 6'd3);
    chk("R7 blocking push stalls", {63'd0, cap_st}, 64'd1);
    acc(VIEW_TAG, 1'b1, 1'b0, 0, 0);
    chk("R7 tag after refused push", {32'd0, cap_rd}, 64'h30220002);
    for (int i = 0; i < 8; i++) begin
      acc(VIEW_NB, 1'b1, 1'b0, 0, 6'd0);
      chk("R3 wrap order", {32'd0, cap_rd}, 64'h100 + 64'(i));
      chk("R8 wake on first pop only", cap_wk, (i == 0) ? 64'h8 : 64'h0);
    end
    acc(VIEW_TAG, 1'b1, 1'b0, 0, 0);
    chk("R5 tag after drain", {32'd0, cap_rd}, 64'h30020001);

    // R2: tag writes
    acc(VIEW_NB, 1'b0, 1'b1, 32'h55, 6'd0);
    acc(VIEW_NB, 1'b0, 1'b1, 32'h66, 6'd0);
    acc(VIEW_TAG, 1'b0, 1'b1, 32'hFFFF_FFFE, 6'd0);
    acc(VIEW_TAG, 1'b1, 1'b0, 0, 0);
    chk("R2 tag write T F", {32'd0, cap_rd}, 64'h300B0002);
    acc(VIEW_TAG, 1'b0, 1'b1, 32'h0000_0001, 6'd0);
    acc(VIEW_TAG, 1'b1, 1'b0, 0, 0);
    chk("R2 tag write E clears count", {32'd0, cap_rd}, 64'h30020001);
    acc(VIEW_NB, 1'b1, 1'b0, 0, 6'd0);
    chk("R2 pop after count clear", {32'd0, cap_rd}, 64'h0);
    // R9: raw write with count 0 ignored; stale word still peeks
    acc(VIEW_RAW, 1'b0, 1'b1, 32'h77, 6'd0);
    acc(VIEW_RAW, 1'b1, 1'b0, 0, 0);
    chk("R9 raw write at count 0 ignored", {32'd0, cap_rd}, 64'h55);
    acc(VIEW_TAG, 1'b1, 1'b0, 0, 0);
    chk("R9 raw write leaves tag", {32'd0, cap_rd}, 64'h30020001);

    // R10: tagged-word variant
    do_reset();
    acc(VIEW_TAG, 1'b1, 1'b0, 0, 0);
    chk("R10 reset tag", {32'd0, cap_rd_nf}, 64'h0);
    acc(VIEW_BLK, 1'b1, 1'b0, 0, 6'd2);
    chk("R10 blocking pop data", {32'd0, cap_rd_nf}, 64'h0);
    chk("R10 blocking pop no stall", {63'd0, cap_st_nf}, 64'd0);
    acc(VIEW_TAG, 1'b0, 1'b1, 32'h1, 6'd0);
    acc(VIEW_NB, 1'b0, 1'b1, 32'h99, 6'd0);
    acc(VIEW_BLK, 1'b0, 1'b1, 32'h99, 6'd2);
    chk("R10 blocking push no stall", {63'd0, cap_st_nf}, 64'd0);
    acc(VIEW_TAG, 1'b1, 1'b0, 0, 0);
    chk("R10 tag unchanged by pushes", {32'd0, cap_rd_nf}, 64'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule